// File: doc/BRIEF.md
# Inrush Current Limit Ramp Generator

This block produces the digital current-limit setpoint that a hot-plug switch controller follows while it turns its pass switch on. A start command makes the setpoint climb linearly from zero to a programmable charging limit over a programmable rise time. The ramp advances once per strobe tick, and the strobe comes from a clock prescaler. When the switch reports that its drain-source voltage has collapsed, meaning the load capacitor is charged, the setpoint moves to a larger steady-state overcurrent limit and a done flag rises. An abort, used for any start-up fault, returns the setpoint to zero at once.

The per-tick increment is worked out at start by a serial divider as quotient and remainder. A remainder accumulator then spreads the fractional part, so the setpoint after `k` ticks is exactly `floor(C*k/T)` and lands on the charging limit `C` at tick `T`. Conversion to an analog level and the regulation loop sit outside the block.

Top module: `inrush_ramp_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `setpoint_o` is 0 and `done_o` is 0.
- R2: An accepted start (`start_i`=1 with `abort_i`=0) captures C=`chg_lim_i` and T=`rise_i`. Ticks come every PRESCALE cycles, counted from the start edge. Once the rising edge that ends tick k has passed, `setpoint_o` equals floor(C*k/T) for 1 ≤ k ≤ T. The preparation phase lasts CUR_W+1 cycles and requires PRESCALE ≥ CUR_W+2.
- R3: After tick T the setpoint saturates at C and holds there while the ramp phase lasts.
- R4: `vds_low_i`=1 at a rising edge during the ramp phase hands over. From that edge on, `setpoint_o` equals the steady limit captured at start, and `done_o` is 1 from the same edge.
- R5: Once set, `done_o` and the steady setpoint remain until the next start or abort. A later fall of `vds_low_i` has no effect.
- R6: `abort_i`=1 at an edge forces `setpoint_o`=0 and `done_o`=0 from that edge and leaves the block idle. Abort takes priority over a simultaneous start, which is then ignored.
- R7: A start that arrives while a ramp is running restarts the ramp from 0. The setpoint is 0 from the start edge, and tick timing counts again from that edge.
- R8: Changes to `chg_lim_i`, `ss_lim_i` and `rise_i` after the start edge have no effect until the next start.
- R9: `vds_low_i` has no effect while the block is idle, nor during the CUR_W+1 preparation cycles that follow a start.
- R10: A rise time of 0 is treated as 1: the setpoint goes from 0 to C at the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start (or restart) a ramp |
| abort_i | input | 1 | Fault abort; setpoint to zero |
| chg_lim_i | input | CUR_W | Charging current limit code C |
| ss_lim_i | input | CUR_W | Steady-state overcurrent limit code |
| rise_i | input | RISE_W | Rise time T in strobe ticks |
| vds_low_i | input | 1 | Drain-source voltage below handover level |
| setpoint_o | output | CUR_W | Current-limit setpoint code |
| done_o | output | 1 | Handover to steady limit has occurred |

## Verification
The bench builds the block with CUR_W=8, RISE_W=5 and PRESCALE=12. That prescale is only two cycles above the minimum, so the first tick lands just after the divider finishes, and a one-cycle slip in preparation or tick timing shows up as a wrong value at a tick edge. With a 5-bit rise field, the longest possible ramp (T=31) can be walked tick by tick, and so can full saturation. Small codes let the bench reach a zero quotient with a nonzero remainder (C=5, T=20), a full-scale charging limit (C=255), and rise time 0.

// File: rtl/inrush_ramp_pkg.sv
package inrush_ramp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_PREP   = 2'd1,
    PH_RAMP   = 2'd2,
    PH_STEADY = 2'd3
  } ramp_phase_e;
endpackage

// File: rtl/ramp_divider.sv
// Serial restoring divider: one quotient bit per cycle, NUM_W cycles.
module ramp_divider #(
  parameter int NUM_W = 12,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic [DEN_W-1:0] rem_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  function automatic logic [DEN_W:0] shift_in(input logic [DEN_W-1:0] r, input logic b);
    return {r, b};
  endfunction

  logic [DEN_W:0] trial_w;
  logic           fits_w;
  logic [DEN_W-1:0] rem_next_w;

  assign trial_w    = shift_in(rem_q, quo_q[NUM_W-1]);
  assign fits_w     = trial_w >= {1'b0, den_q};
  assign rem_next_w = fits_w ? DEN_W'(trial_w - {1'b0, den_q}) : trial_w[DEN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_i) begin
      quo_q  <= num_i;
      rem_q  <= '0;
      den_q  <= den_i;
      cnt_q  <= CNT_W'(NUM_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      quo_q <= {quo_q[NUM_W-2:0], fits_w};
      rem_q <= rem_next_w;
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
  assign done_o = done_q;
endmodule

// File: rtl/ramp_strobe.sv
// Prescaler: one-cycle tick every DIV cycles, restarted by clear_i.
module ramp_strobe #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (cnt_q == LAST)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + PW'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/ramp_accum.sv
// Linear ramp: level += step per tick plus a carry from the remainder accumulator.
module ramp_accum #(
  parameter int CUR_W  = 12,
  parameter int RISE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_en_i,
  input  logic [CUR_W-1:0]  step_i,
  input  logic [RISE_W-1:0] rem_i,
  input  logic [RISE_W-1:0] span_i,
  output logic [CUR_W-1:0]  level_o,
  output logic              full_o
);
  logic [CUR_W-1:0]  lvl_q;
  logic [RISE_W-1:0] frac_q;
  logic [RISE_W-1:0] k_q;

  function automatic logic [RISE_W:0] frac_add(input logic [RISE_W-1:0] f,
                                               input logic [RISE_W-1:0] r);
    return {1'b0, f} + {1'b0, r};
  endfunction

  logic [RISE_W:0] sum_w;
  logic            carry_w;

  assign sum_w   = frac_add(frac_q, rem_i);
  assign carry_w = sum_w >= {1'b0, span_i};
  assign full_o  = (k_q == span_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      frac_q <= '0;
      k_q    <= '0;
    end else if (clear_i) begin
      lvl_q  <= '0;
      frac_q <= '0;
      k_q    <= '0;
    end else if (step_en_i && !full_o) begin
      k_q <= k_q + RISE_W'(1);
      if (carry_w) begin
        frac_q <= RISE_W'(sum_w - {1'b0, span_i});
        lvl_q  <= lvl_q + step_i + CUR_W'(1);
      end else begin
        frac_q <= sum_w[RISE_W-1:0];
        lvl_q  <= lvl_q + step_i;
      end
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/ramp_phase_ctrl.sv
module ramp_phase_ctrl
  import inrush_ramp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_go_i,
  input  logic        abort_i,
  input  logic        div_done_i,
  input  logic        vds_low_i,
  output ramp_phase_e phase_o,
  output logic        done_o,
  output logic        handover_o
);
  ramp_phase_e phase_q;
  logic        done_q;

  assign handover_o = (phase_q == PH_RAMP) && vds_low_i && !abort_i && !start_go_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else if (abort_i) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else if (start_go_i) begin
      phase_q <= PH_PREP;
      done_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_PREP: if (div_done_i) phase_q <= PH_RAMP;
        PH_RAMP: if (vds_low_i) begin
          phase_q <= PH_STEADY;
          done_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;
endmodule

// File: rtl/inrush_ramp_gen.sv
module inrush_ramp_gen
  import inrush_ramp_pkg::*;
#(
  parameter int CUR_W    = 12,
  parameter int RISE_W   = 14,
  parameter int PRESCALE = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [CUR_W-1:0]  chg_lim_i,
  input  logic [CUR_W-1:0]  ss_lim_i,
  input  logic [RISE_W-1:0] rise_i,
  input  logic              vds_low_i,
  output logic [CUR_W-1:0]  setpoint_o,
  output logic              done_o
);
  function automatic logic [RISE_W-1:0] span_of(input logic [RISE_W-1:0] r);
    return (r == '0) ? RISE_W'(1) : r;
  endfunction

  // named internal events, observed by the bound checker
  logic start_go_w;
  logic handover_w;
  logic ph_ramp_w;
  logic tick_w;
  logic div_done_w;

  logic [CUR_W-1:0]  chg_q;
  logic [CUR_W-1:0]  ss_q;
  logic [RISE_W-1:0] span_q;
  logic [CUR_W-1:0]  step_w;
  logic [RISE_W-1:0] rem_w;
  logic [CUR_W-1:0]  level_w;
  logic              full_w;
  ramp_phase_e       phase_w;

  assign start_go_w = start_i && !abort_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q  <= '0;
      ss_q   <= '0;
      span_q <= RISE_W'(1);
    end else if (start_go_w) begin
      chg_q  <= chg_lim_i;
      ss_q   <= ss_lim_i;
      span_q <= span_of(rise_i);
    end
  end

  ramp_divider #(.NUM_W(CUR_W), .DEN_W(RISE_W)) div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_go_w),
    .num_i  (chg_lim_i),
    .den_i  (span_of(rise_i)),
    .quo_o  (step_w),
    .rem_o  (rem_w),
    .done_o (div_done_w)
  );

  ramp_strobe #(.DIV(PRESCALE)) strobe_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_go_w),
    .tick_o  (tick_w)
  );

  ramp_accum #(.CUR_W(CUR_W), .RISE_W(RISE_W)) accum_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_go_w),
    .step_en_i (tick_w && ph_ramp_w),
    .step_i    (step_w),
    .rem_i     (rem_w),
    .span_i    (span_q),
    .level_o   (level_w),
    .full_o    (full_w)
  );

  ramp_phase_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_go_i (start_go_w),
    .abort_i    (abort_i),
    .div_done_i (div_done_w),
    .vds_low_i  (vds_low_i),
    .phase_o    (phase_w),
    .done_o     (done_o),
    .handover_o (handover_w)
  );

  assign ph_ramp_w = (phase_w == PH_RAMP);

  always_comb begin
    case (phase_w)
      PH_RAMP:   setpoint_o = full_w ? chg_q : level_w;
      PH_STEADY: setpoint_o = ss_q;
      default:   setpoint_o = '0;
    endcase
  end
endmodule

// File: rtl/inrush_ramp_chk.sv
module inrush_ramp_chk #(
  parameter int CUR_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             abort_i,
  input logic             start_go_w,
  input logic             handover_w,
  input logic             ph_ramp_w,
  input logic [CUR_W-1:0] chg_q,
  input logic [CUR_W-1:0] setpoint_o,
  input logic             done_o
);
  p_abort_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (setpoint_o == '0 && !done_o));

  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_go_w |=> (setpoint_o == '0 && !done_o));

  p_handover_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    handover_w |=> done_o);

  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i && !abort_i) |=> (done_o && $stable(setpoint_o)));

  p_ramp_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_ramp_w && $past(ph_ramp_w)) |-> (setpoint_o >= $past(setpoint_o)));

  p_ramp_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ph_ramp_w |-> (setpoint_o <= chg_q));
endmodule

bind inrush_ramp_gen inrush_ramp_chk #(.CUR_W(CUR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .abort_i    (abort_i),
  .start_go_w (start_go_w),
  .handover_w (handover_w),
  .ph_ramp_w  (ph_ramp_w),
  .chg_q      (chg_q),
  .setpoint_o (setpoint_o),
  .done_o     (done_o)
);

// File: tb/inrush_ramp_gen_tb_top.sv
module inrush_ramp_gen_tb_top;
  localparam int CW = 8;
  localparam int RW = 5;
  localparam int PS = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          abort_i = 1'b0;
  logic          vds_low_i = 1'b0;
  logic [CW-1:0] chg_i = '0;
  logic [CW-1:0] ss_i = '0;
  logic [RW-1:0] rise_i = '0;
  logic [CW-1:0] setpoint_o;
  logic          done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  inrush_ramp_gen #(.CUR_W(CW), .RISE_W(RW), .PRESCALE(PS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .chg_lim_i(chg_i), .ss_lim_i(ss_i), .rise_i(rise_i), .vds_low_i(vds_low_i),
    .setpoint_o(setpoint_o), .done_o(done_o)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // floor(C*k/T) with T=0 read as 1 and k saturating at T
  function automatic int ramp_ref(int c, int t, int k);
    int tt = (t == 0) ? 1 : t;
    int kk = (k > tt) ? tt : k;
    return (c * kk) / tt;
  endfunction

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  // returns half a cycle after the start edge
  task automatic fire(int c, int s, int t);
    @(negedge clk);
    chg_i = CW'(c); ss_i = CW'(s); rise_i = RW'(t); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic go_idle();
    @(negedge clk); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 setpoint in reset", int'(setpoint_o), 0);
    check("R1 done in reset", int'(done_o), 0);
    @(negedge clk); rst_n = 1'b1;
    edges(3);
    check("R1 setpoint after reset", int'(setpoint_o), 0);
    check("R1 done after reset", int'(done_o), 0);
  endtask

  task automatic run_ramp(int c, int t);
    int pos = 0;
    fire(c, 0, t);
    for (int k = 1; k <= t + 2; k++) begin
      edges(k * PS - 1 - pos); pos = k * PS - 1;
      check("R2 before tick", int'(setpoint_o), ramp_ref(c, t, k - 1));
      edges(1); pos++;
      if (k > t) check("R3 saturated", int'(setpoint_o), c);
      else       check("R2 at tick", int'(setpoint_o), ramp_ref(c, t, k));
    end
    check("R2 done low while ramping", int'(done_o), 0);
  endtask

  task automatic t_zero_rise();
    fire(77, 0, 0);
    edges(PS - 1);
    check("R10 before first tick", int'(setpoint_o), 0);
    edges(1);
    check("R10 full after first tick", int'(setpoint_o), 77);
  endtask

  task automatic t_handover();
    fire(100, 230, 10);
    edges(3 * PS);
    check("R2 pre-handover level", int'(setpoint_o), 30);
    check("R4 done low pre-handover", int'(done_o), 0);
    vds_low_i = 1'b1;
    edges(1);
    check("R4 steady setpoint", int'(setpoint_o), 230);
    check("R4 done with handover", int'(done_o), 1);
    vds_low_i = 1'b0;
    ss_i = CW'(9);
    edges(20);
    check("R5 steady held, R8 ss change ignored", int'(setpoint_o), 230);
    check("R5 done held", int'(done_o), 1);
  endtask

  task automatic t_abort();
    @(negedge clk);
    abort_i = 1'b1; start_i = 1'b1; chg_i = CW'(50); rise_i = RW'(1);
    @(negedge clk);
    abort_i = 1'b0; start_i = 1'b0;
    check("R6 setpoint cleared", int'(setpoint_o), 0);
    check("R6 done cleared", int'(done_o), 0);
    edges(3 * PS);
    check("R6 start under abort ignored", int'(setpoint_o), 0);
  endtask

  task automatic t_restart();
    fire(60, 0, 4);
    edges(2 * PS);
    check("R7 mid ramp", int'(setpoint_o), 30);
    fire(60, 0, 4);
    check("R7 zero after restart", int'(setpoint_o), 0);
    edges(PS - 1);
    check("R7 tick timing restarted", int'(setpoint_o), 0);
    edges(1);
    check("R7 first tick after restart", int'(setpoint_o), 15);
  endtask

  task automatic t_latch();
    fire(120, 0, 6);
    chg_i = CW'(3); rise_i = RW'(1);
    edges(3 * PS);
    check("R8 operands latched", int'(setpoint_o), 60);
  endtask

  task automatic t_vds_ignore();
    go_idle();
    vds_low_i = 1'b1;
    edges(5);
    check("R9 idle setpoint", int'(setpoint_o), 0);
    check("R9 idle done", int'(done_o), 0);
    vds_low_i = 1'b0;
    fire(90, 200, 9);
    vds_low_i = 1'b1;
    edges(4);
    vds_low_i = 1'b0;
    edges(PS - 4);
    check("R9 prep vds ignored level", int'(setpoint_o), 10);
    check("R9 prep vds ignored done", int'(done_o), 0);
  endtask

  initial begin
    edges(4);
    t_reset();
    run_ramp(200, 7);
    run_ramp(255, 31);
    run_ramp(5, 20);
    t_zero_rise();
    t_handover();
    t_abort();
    t_restart();
    t_latch();
    t_vds_ignore();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule